// File: doc/BRIEF.md
# Pipeline Hazard and Bus Arbitration Controller

This block steers an in-order five-stage pipeline (fetch, decode, execute, memory access, writeback) in which instruction fetches and data loads and stores share one memory port. The block owns the valid bit of every pipeline register from decode onward. The datapath reports the register fields and the operation flags of the instruction in each stage, and the branch outcome computed in execute. The block returns the operand bypass selects for execute, the hold and bubble controls for the front end, the branch redirect and squash, and the grant for the shared port in each cycle.

Three hazards are handled. Read-after-write dependences are bypassed from the two older stages, and the younger producer wins. A load that is followed at once by a consumer of its result costs one bubble. A taken branch squashes the wrong-path work that has already been fetched. A load or store in the memory stage takes the shared port away from fetch. The front end then holds for that cycle and a bubble enters execute. Independent, non-memory code retires one instruction per cycle once the pipeline has filled.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While the asynchronous active-low reset is asserted and in the first cycle after it is released (with no fetch request), all four stage valid outputs are 0, and hold, bubble, redirect, squash, both grants, fetch_take and both bypass selects are 0.
- R2: Each bypass select (fwd_a for exe_rs1, fwd_b for exe_rs2) is 2'd1 when the valid memory-stage instruction writes (mem_wen=1) a nonzero register equal to the source. It is 2'd2 when only the valid writeback-stage instruction does so (wb_wen=1). Otherwise it is 2'd0, which selects the register file.
- R3: When both the memory-stage and the writeback-stage instructions match a source, the select is 2'd1.
- R4: Register 0, a producer with its write enable low, or a producer whose stage is not valid never causes a bypass or a stall.
- R5: When the valid execute instruction is a load (exe_load=1, exe_wen=1) writing a nonzero register that equals dec_rs1 or dec_rs2 of a valid decode instruction, dec_hold and exe_bubble are 1 and fetch_take is 0. In the next cycle exe_valid is 0 and dec_valid is unchanged.
- R6: A valid execute instruction with exe_br_taken=1 raises pc_redirect and dec_flush, forces dec_hold, exe_bubble and fetch_take to 0, and leaves dec_valid and exe_valid at 0 in the next cycle. This holds even when a load-use or port conflict exists in the same cycle.
- R7: mem_gnt is 1 exactly when the valid memory-stage instruction accesses memory (mem_access=1). fetch_gnt equals fetch_req when that is not the case and is 0 otherwise. The two grants are never 1 together.
- R8: A fetch request in a cycle where the memory stage holds the port raises dec_hold and exe_bubble and keeps fetch_take at 0, unless a redirect is active.
- R9: In every cycle without reset, exe_valid moves to mem_valid and mem_valid moves to wb_valid. dec_valid becomes fetch_take whenever decode is not held.
- R10: Twenty independent non-memory instructions requested back to back retire in consecutive cycles, and the last writeback occurs in cycle 24, counting the first fetch cycle as 1.
- R11: A datapath that obeys these controls leaves the same register and data memory contents as executing the same program one instruction at a time. The programs mix dependent ALU operations, loads, stores and taken branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Front end has an instruction to fetch |
| dec_rs1 | input | REG_AW | First source register of the decode instruction |
| dec_rs2 | input | REG_AW | Second source register of the decode instruction |
| exe_rs1 | input | REG_AW | First source register of the execute instruction |
| exe_rs2 | input | REG_AW | Second source register of the execute instruction |
| exe_rd | input | REG_AW | Destination register of the execute instruction |
| exe_wen | input | 1 | Execute instruction writes a register |
| exe_load | input | 1 | Execute instruction is a load |
| exe_br_taken | input | 1 | Execute instruction is a branch whose condition holds |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_access | input | 1 | Memory-stage instruction is a load or a store |
| wb_rd | input | REG_AW | Destination register of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Bypass select for the first execute operand |
| fwd_b | output | 2 | Bypass select for the second execute operand |
| fetch_gnt | output | 1 | Shared port granted to fetch |
| mem_gnt | output | 1 | Shared port granted to the memory stage |
| fetch_take | output | 1 | Fetched word is captured and the program counter advances |
| pc_redirect | output | 1 | Program counter loads the branch target |
| dec_hold | output | 1 | Decode register keeps its contents |
| exe_bubble | output | 1 | Execute register is loaded with a bubble |
| dec_flush | output | 1 | Decode contents and the current fetch are squashed |
| dec_valid | output | 1 | Decode stage holds a live instruction |
| exe_valid | output | 1 | Execute stage holds a live instruction |
| mem_valid | output | 1 | Memory stage holds a live instruction |
| wb_valid | output | 1 | Writeback stage holds a live instruction |

## Verification
Every cycle, the assertions check that the two grants are exclusive and that a redirect overrides both stall sources. They also check that a hold keeps the decode valid bit and empties execute, that a squash clears both front stages, and that valid bits advance one stage per cycle. Whether the bypass choices are right in value, and whether a stall comes late or is missing, can only be seen by running programs. The bench does this against a sequential model of the same program and through the 24-cycle fill-and-drain count.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Operand source chosen for an execute operand
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_sel_e;

  // Valid bits of the pipeline registers after fetch
  typedef struct packed {
    logic dec;
    logic exe;
    logic mem;
    logic wb;
  } stage_vld_t;
endpackage

// File: rtl/ph_fwd_select.sv
module ph_fwd_select
  import pipe_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          mem_v,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_v,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_rd,
  output fwd_sel_e      sel
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic mem_hit;
  logic wb_hit;

  always_comb begin
    mem_hit = mem_v & mem_wen & (mem_rd != ZERO_REG) & (mem_rd == src);
    wb_hit  = wb_v & wb_wen & (wb_rd != ZERO_REG) & (wb_rd == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == ZERO_REG) |-> (sel == FWD_RF));

  // R4
  dead_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> (wb_v && wb_wen));
endmodule

// File: rtl/ph_hazard_detect.sv
module ph_hazard_detect #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_v,
  input  logic          exe_v,
  input  logic          mem_v,
  input  logic          fetch_req,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_wen,
  input  logic          exe_load,
  input  logic          exe_br_taken,
  input  logic          mem_access,
  output logic          fetch_gnt,
  output logic          mem_gnt,
  output logic          fetch_take,
  output logic          redirect,
  output logic          hold
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AW-1:0] ZERO_REG = '0;

  logic load_use;
  logic port_busy;
  logic port_clash;

  always_comb begin
    load_use   = dec_v & exe_v & exe_load & exe_wen & (exe_rd != ZERO_REG)
               & ((exe_rd == dec_rs1) | (exe_rd == dec_rs2));
    port_busy  = mem_v & mem_access;
    port_clash = fetch_req & port_busy;
    redirect   = exe_v & exe_br_taken;
    hold       = ~redirect & (load_use | port_clash);
    mem_gnt    = port_busy;
    fetch_gnt  = fetch_req & ~port_busy;
    fetch_take = fetch_gnt & ~hold & ~redirect;
  end

  // R7
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_gnt && mem_gnt));

  // R8
  clash_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && mem_v && mem_access && !redirect) |-> (hold && !fetch_take));

  // R6
  redirect_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!hold && !fetch_take));
endmodule

// File: rtl/ph_valid_pipe.sv
module ph_valid_pipe
  import pipe_hazard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_take,
  input  logic       hold,
  input  logic       flush,
  output stage_vld_t vld
);
  timeunit 1ns;
  timeprecision 1ps;

  stage_vld_t vld_q;
  stage_vld_t vld_d;
  logic       dec_en;

  always_comb begin
    dec_en    = ~hold;
    vld_d.dec = fetch_take;
    vld_d.exe = vld_q.dec & ~(hold | flush);
    vld_d.mem = vld_q.exe;
    vld_d.wb  = vld_q.mem;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (dec_en) vld_q.dec <= vld_d.dec;
      vld_q.exe <= vld_d.exe;
      vld_q.mem <= vld_d.mem;
      vld_q.wb  <= vld_d.wb;
    end
  end

  assign vld = vld_q;

  // R5
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!vld.exe && (vld.dec == $past(vld.dec))));

  // R6
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!vld.dec && !vld.exe));

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld.mem |=> vld.wb);

  // R9
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |=> vld.dec);
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import pipe_hazard_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic [REG_AW-1:0] exe_rs1,
  input  logic [REG_AW-1:0] exe_rs2,
  input  logic [REG_AW-1:0] exe_rd,
  input  logic              exe_wen,
  input  logic              exe_load,
  input  logic              exe_br_taken,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_access,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              fetch_gnt,
  output logic              mem_gnt,
  output logic              fetch_take,
  output logic              pc_redirect,
  output logic              dec_hold,
  output logic              exe_bubble,
  output logic              dec_flush,
  output logic              dec_valid,
  output logic              exe_valid,
  output logic              mem_valid,
  output logic              wb_valid
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NUM_SRC = 2;

  stage_vld_t        vld;
  logic              hold;
  logic              redirect;
  logic              take;
  logic [REG_AW-1:0] src_reg [NUM_SRC];
  fwd_sel_e          src_sel [NUM_SRC];

  assign src_reg[0] = exe_rs1;
  assign src_reg[1] = exe_rs2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ph_fwd_select #(.AW(REG_AW)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_reg[g]),
      .mem_v   (vld.mem),
      .mem_wen (mem_wen),
      .mem_rd  (mem_rd),
      .wb_v    (vld.wb),
      .wb_wen  (wb_wen),
      .wb_rd   (wb_rd),
      .sel     (src_sel[g])
    );
  end

  ph_hazard_detect #(.AW(REG_AW)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_v        (vld.dec),
    .exe_v        (vld.exe),
    .mem_v        (vld.mem),
    .fetch_req    (fetch_req),
    .dec_rs1      (dec_rs1),
    .dec_rs2      (dec_rs2),
    .exe_rd       (exe_rd),
    .exe_wen      (exe_wen),
    .exe_load     (exe_load),
    .exe_br_taken (exe_br_taken),
    .mem_access   (mem_access),
    .fetch_gnt    (fetch_gnt),
    .mem_gnt      (mem_gnt),
    .fetch_take   (take),
    .redirect     (redirect),
    .hold         (hold)
  );

  ph_valid_pipe u_vpipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_take (take),
    .hold       (hold),
    .flush      (redirect),
    .vld        (vld)
  );

  assign fwd_a       = src_sel[0];
  assign fwd_b       = src_sel[1];
  assign fetch_take  = take;
  assign pc_redirect = redirect;
  assign dec_flush   = redirect;
  assign dec_hold    = hold;
  assign exe_bubble  = hold;
  assign dec_valid   = vld.dec;
  assign exe_valid   = vld.exe;
  assign mem_valid   = vld.mem;
  assign wb_valid    = vld.wb;

  // R2
  fwd_mem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'd1) |-> (mem_valid && mem_wen));

  // R6
  squash_vs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> (!dec_hold && !exe_bubble));

  // R9
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |=> !wb_valid);
endmodule

// File: tb/pipe_hazard_unit_tb.sv
module pipe_hazard_unit_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW   = 5;
  localparam int MAXP = 64;
  localparam int OP_NOP = 0, OP_ALU = 1, OP_LD = 2, OP_ST = 3, OP_BEQ = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic fetch_req, exe_wen, exe_load, exe_br_taken, mem_wen, mem_access, wb_wen;
  logic [AW-1:0] dec_rs1, dec_rs2, exe_rs1, exe_rs2, exe_rd, mem_rd, wb_rd;
  logic [1:0] fwd_a, fwd_b;
  logic fetch_gnt, mem_gnt, fetch_take, pc_redirect, dec_hold, exe_bubble, dec_flush;
  logic dec_valid, exe_valid, mem_valid, wb_valid;

  int tests = 0;
  int fails = 0;

  // program store and datapath model state
  int p_op [MAXP], p_rd [MAXP], p_rs1 [MAXP], p_rs2 [MAXP], p_imm [MAXP], p_tgt [MAXP];
  int plen = 0;
  int pc = 0, d_idx = 0, e_idx = 0, m_idx = 0, w_idx = 0;
  bit v_d = 0, v_e = 0, v_m = 0, v_w = 0;
  int unsigned e_a = 0, e_b = 0, m_res = 0, m_st = 0, w_val = 0;
  int unsigned regs [32];
  int unsigned dmem [16];

  assign fetch_req  = (pc < plen);
  assign dec_rs1    = p_rs1[d_idx][AW-1:0];
  assign dec_rs2    = p_rs2[d_idx][AW-1:0];
  assign exe_rs1    = p_rs1[e_idx][AW-1:0];
  assign exe_rs2    = p_rs2[e_idx][AW-1:0];
  assign exe_rd     = p_rd[e_idx][AW-1:0];
  assign exe_wen    = (p_op[e_idx] == OP_ALU) || (p_op[e_idx] == OP_LD);
  assign exe_load   = (p_op[e_idx] == OP_LD);
  assign mem_rd     = p_rd[m_idx][AW-1:0];
  assign mem_wen    = (p_op[m_idx] == OP_ALU) || (p_op[m_idx] == OP_LD);
  assign mem_access = (p_op[m_idx] == OP_LD) || (p_op[m_idx] == OP_ST);
  assign wb_rd      = p_rd[w_idx][AW-1:0];
  assign wb_wen     = (p_op[w_idx] == OP_ALU) || (p_op[w_idx] == OP_LD);

  pipe_hazard_unit #(.REG_AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .exe_rs1(exe_rs1), .exe_rs2(exe_rs2),
    .exe_rd(exe_rd), .exe_wen(exe_wen), .exe_load(exe_load), .exe_br_taken(exe_br_taken),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_access(mem_access),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fetch_gnt(fetch_gnt), .mem_gnt(mem_gnt),
    .fetch_take(fetch_take), .pc_redirect(pc_redirect), .dec_hold(dec_hold),
    .exe_bubble(exe_bubble), .dec_flush(dec_flush), .dec_valid(dec_valid),
    .exe_valid(exe_valid), .mem_valid(mem_valid), .wb_valid(wb_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit writes(input int op);
    return (op == OP_ALU) || (op == OP_LD);
  endfunction

  // expected bypass select from the requirements (R2 R3 R4)
  function automatic logic [1:0] ref_fwd(input int src);
    if (src != 0 && v_m && writes(p_op[m_idx]) && p_rd[m_idx] == src) return 2'd1;
    if (src != 0 && v_w && writes(p_op[w_idx]) && p_rd[w_idx] == src) return 2'd2;
    return 2'd0;
  endfunction

  function automatic int unsigned pick(input logic [1:0] s, input int unsigned rf);
    if (s == 2'd1) return m_res;
    if (s == 2'd2) return w_val;
    return rf;
  endfunction

  // register read in decode, with same-cycle writeback visible
  function automatic int unsigned rf_read(input int r);
    if (r == 0) return 0;
    if (v_w && writes(p_op[w_idx]) && p_rd[w_idx] == r) return w_val;
    return regs[r];
  endfunction

  function automatic bit calc_taken();
    return (p_op[e_idx] == OP_BEQ) &&
           (pick(ref_fwd(p_rs1[e_idx]), e_a) == pick(ref_fwd(p_rs2[e_idx]), e_b));
  endfunction

  task automatic init_data();
    for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 0 : i % 3;
    for (int i = 0; i < 16; i++) dmem[i] = i * 7 + 1;
  endtask

  task automatic step(input int cyc, inout int last_wb, inout int n_wb);
    logic [1:0] fa, fb;
    int unsigned a, b, nm_res, nw_val, ne_a, ne_b;
    bit lu, redir, mbusy, freq, clash, hold, fgnt, take, nv_e, nv_d;
    int e_op, ne_idx, nd_idx, npc;
    @(negedge clk);
    e_op  = p_op[e_idx];
    fa    = ref_fwd(p_rs1[e_idx]);
    fb    = ref_fwd(p_rs2[e_idx]);
    a     = pick(fa, e_a);
    b     = pick(fb, e_b);
    lu    = v_d && v_e && e_op == OP_LD && p_rd[e_idx] != 0 &&
            (p_rd[e_idx] == p_rs1[d_idx] || p_rd[e_idx] == p_rs2[d_idx]);
    redir = v_e && e_op == OP_BEQ && a == b;
    mbusy = v_m && (p_op[m_idx] == OP_LD || p_op[m_idx] == OP_ST);
    freq  = pc < plen;
    clash = freq && mbusy;
    hold  = !redir && (lu || clash);
    fgnt  = freq && !mbusy;
    take  = fgnt && !hold && !redir;
    chk(fwd_a == fa, "R2 R3 R4 fwd_a", int'(fwd_a), int'(fa));
    chk(fwd_b == fb, "R2 R3 R4 fwd_b", int'(fwd_b), int'(fb));
    chk({fetch_gnt, mem_gnt} == {fgnt, mbusy}, "R7 grants",
        int'({fetch_gnt, mem_gnt}), int'({fgnt, mbusy}));
    chk({dec_hold, exe_bubble, fetch_take} == {hold, hold, take}, "R5 R8 hold/bubble/take",
        int'({dec_hold, exe_bubble, fetch_take}), int'({hold, hold, take}));
    chk({pc_redirect, dec_flush} == {redir, redir}, "R6 redirect/squash",
        int'({pc_redirect, dec_flush}), int'({redir, redir}));
    chk({dec_valid, exe_valid, mem_valid, wb_valid} == {v_d, v_e, v_m, v_w}, "R9 valids",
        int'({dec_valid, exe_valid, mem_valid, wb_valid}), int'({v_d, v_e, v_m, v_w}));
    if (wb_valid) begin
      last_wb = cyc;
      n_wb++;
    end
    // next state of the behavioural datapath
    nw_val = (p_op[m_idx] == OP_LD) ? dmem[m_res & 15] : m_res;
    case (e_op)
      OP_ALU:        nm_res = a + b + p_imm[e_idx];
      OP_LD, OP_ST:  nm_res = (a + p_imm[e_idx]) & 15;
      default:       nm_res = 0;
    endcase
    nv_e = !(hold || redir) && v_d;
    ne_idx = (hold || redir) ? e_idx : d_idx;
    ne_a = rf_read(p_rs1[d_idx]);
    ne_b = rf_read(p_rs2[d_idx]);
    nv_d = hold ? v_d : take;
    nd_idx = take ? pc : d_idx;
    npc = redir ? p_tgt[e_idx] : (take ? pc + 1 : pc);
    @(posedge clk);
    #1;
    if (v_w && writes(p_op[w_idx]) && p_rd[w_idx] != 0) regs[p_rd[w_idx]] = w_val;
    if (v_m && p_op[m_idx] == OP_ST) dmem[m_res & 15] = m_st;
    v_w = v_m;  w_idx = m_idx;  w_val = nw_val;
    v_m = v_e;  m_idx = e_idx;  m_res = nm_res;  m_st = b;
    v_e = nv_e; e_idx = ne_idx;
    if (!(hold || redir)) begin
      e_a = ne_a;
      e_b = ne_b;
    end
    v_d = nv_d; d_idx = nd_idx;
    pc = npc;
    exe_br_taken = calc_taken();
  endtask

  task automatic run_prog(output int last_wb, output int n_wb);
    int cyc = 0;
    last_wb = 0;
    n_wb = 0;
    pc = 0;
    exe_br_taken = calc_taken();
    while (!(pc >= plen && !v_d && !v_e && !v_m && !v_w)) begin
      cyc++;
      step(cyc, last_wb, n_wb);
    end
  endtask

  // sequential execution of the same program, compared with the pipelined result (R11)
  task automatic compare_golden(input int unsigned r0 [32], input int unsigned m0 [16]);
    int unsigned gr [32];
    int unsigned gm [16];
    int gpc = 0, guard = 0, bad = 0;
    gr = r0;
    gm = m0;
    while (gpc < plen && guard < 2000) begin
      guard++;
      case (p_op[gpc])
        OP_ALU: if (p_rd[gpc] != 0) gr[p_rd[gpc]] = gr[p_rs1[gpc]] + gr[p_rs2[gpc]] + p_imm[gpc];
        OP_LD:  if (p_rd[gpc] != 0) gr[p_rd[gpc]] = gm[(gr[p_rs1[gpc]] + p_imm[gpc]) & 15];
        OP_ST:  gm[(gr[p_rs1[gpc]] + p_imm[gpc]) & 15] = gr[p_rs2[gpc]];
        default: ;
      endcase
      if (p_op[gpc] == OP_BEQ && gr[p_rs1[gpc]] == gr[p_rs2[gpc]]) gpc = p_tgt[gpc];
      else gpc++;
    end
    for (int i = 0; i < 32; i++) if (gr[i] != regs[i]) bad++;
    for (int i = 0; i < 16; i++) if (gm[i] != dmem[i]) bad++;
    chk(bad == 0, "R11 state mismatches vs sequential", bad, 0);
  endtask

  task automatic set_ins(input int i, input int op, input int rd, input int rs1,
                         input int rs2, input int imm, input int tgt);
    p_op[i] = op; p_rd[i] = rd; p_rs1[i] = rs1; p_rs2[i] = rs2; p_imm[i] = imm; p_tgt[i] = tgt;
  endtask

  task automatic run_checked();
    int unsigned r0 [32];
    int unsigned m0 [16];
    int lw, nw;
    init_data();
    r0 = regs;
    m0 = dmem;
    run_prog(lw, nw);
    compare_golden(r0, m0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: got 0 expected 1 (run completion)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lw, nw, r;
    void'($urandom(32'd20240611));
    exe_br_taken = 1'b0;
    for (int i = 0; i < MAXP; i++) set_ins(i, OP_NOP, 0, 0, 0, 0, 0);
    init_data();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk({dec_valid, exe_valid, mem_valid, wb_valid} == 4'b0, "R1 valids in reset",
        int'({dec_valid, exe_valid, mem_valid, wb_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dec_valid, exe_valid, mem_valid, wb_valid} == 4'b0, "R1 valids after reset",
        int'({dec_valid, exe_valid, mem_valid, wb_valid}), 0);
    chk({dec_hold, exe_bubble, pc_redirect, dec_flush, fetch_gnt, mem_gnt, fetch_take} == 7'b0,
        "R1 controls after reset",
        int'({dec_hold, exe_bubble, pc_redirect, dec_flush, fetch_gnt, mem_gnt, fetch_take}), 0);
    chk({fwd_a, fwd_b} == 4'b0, "R1 bypass selects", int'({fwd_a, fwd_b}), 0);
    @(posedge clk);
    #1;

    // R10: twenty independent ALU operations
    for (int i = 0; i < 20; i++) set_ins(i, OP_ALU, (i % 7) + 1, 0, 0, i, 0);
    plen = 20;
    init_data();
    run_prog(lw, nw);
    chk(lw == 24, "R10 cycle of last writeback", lw, 24);
    chk(nw == 20, "R10 retired count", nw, 20);

    // directed corner program: R3 double match, R5 load-use, R6 squash over port clash, R4 r0
    set_ins(0,  OP_ALU, 1, 0, 0, 5, 0);
    set_ins(1,  OP_ALU, 1, 0, 0, 9, 0);
    set_ins(2,  OP_ALU, 2, 1, 1, 0, 0);
    set_ins(3,  OP_LD,  3, 0, 0, 2, 0);
    set_ins(4,  OP_ALU, 4, 3, 0, 1, 0);
    set_ins(5,  OP_ST,  4, 0, 4, 4, 0);
    set_ins(6,  OP_BEQ, 2, 0, 0, 0, 9);
    set_ins(7,  OP_ALU, 6, 0, 0, 99, 0);
    set_ins(8,  OP_ALU, 7, 0, 0, 77, 0);
    set_ins(9,  OP_ALU, 5, 4, 2, 0, 0);
    set_ins(10, OP_ALU, 0, 0, 0, 1, 0);
    set_ins(11, OP_ALU, 6, 0, 0, 3, 0);
    plen = 12;
    run_checked();
    chk(regs[2] == 18, "R3 youngest producer value", int'(regs[2]), 18);
    chk(regs[7] == 1, "R6 wrong-path write suppressed", int'(regs[7]), 1);
    chk(regs[6] == 3, "R4 r0 not bypassed", int'(regs[6]), 3);

    // back-to-back stores and loads on the shared port (R8)
    set_ins(0, OP_ST, 0, 0, 1, 3, 0);
    set_ins(1, OP_LD, 2, 0, 0, 3, 0);
    set_ins(2, OP_ST, 5, 2, 2, 0, 0);
    set_ins(3, OP_LD, 1, 2, 0, 0, 0);
    set_ins(4, OP_ALU, 3, 1, 2, 0, 0);
    plen = 5;
    run_checked();

    // constrained random programs
    for (int p = 0; p < 40; p++) begin
      plen = 24;
      for (int i = 0; i < plen; i++) begin
        r = $urandom % 100;
        set_ins(i,
                (r < 40) ? OP_ALU : (r < 60) ? OP_LD : (r < 75) ? OP_ST : (r < 90) ? OP_BEQ : OP_NOP,
                $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 16, 0);
        p_tgt[i] = i + 1 + ($urandom % 4);
        if (p_tgt[i] > plen) p_tgt[i] = plen;
      end
      run_checked();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule